// File: doc/BRIEF.md
# Facility Data Link Zero Stuffer and Destuffer

This block carries the bit-level transparency coding for the facility data link of an extended-superframe T1 stream. That link rides in the framing-bit position of every other frame. A data link bit therefore moves only in a sparse set of slots. The surrounding framer marks each slot with a single-cycle strobe, and between strobes nothing in this block advances.

On the transmit side, the block accepts serial link bits. Once it has sent a run of five ones into the slots, it forces a zero into the next slot. It drops a ready signal for that slot so that the source holds its pending bit for one more slot.

On the receive side, the block watches the extracted link bits. It discards a zero that follows a run of exactly five ones. A zero that follows six or more ones is passed on, because such a run cannot come from a stuffed payload. The receive output is registered and keeps its value until the next delivered bit.

Each direction has its own enable. When an enable is low, bits pass through unchanged. Message framing, flags and check sequences belong to the layer above.

Top module: `fdl_link_codec`

## Requirements
- R1: While reset is asserted, both valid outputs are 0, both bit outputs are 0, and `tx_ready` is 1.
- R2: With `tx_stuff_en`=1, after five consecutive ones have been placed into slots, the next slot carries a 0. During that slot `tx_ready` is 0 and the input bit is not consumed.
- R3: With `rx_destuff_en`=1, a received 0 whose preceding run is exactly five ones produces no output pulse.
- R4: With `rx_destuff_en`=1, a received 0 that follows six or more consecutive ones is delivered.
- R5: With an enable at 0, that direction copies every slot bit to its output, and `tx_ready` stays 1.
- R6: Each slot strobe that delivers a bit raises the matching valid output for one clock, one clock after the strobe. No valid pulse appears without a strobe.
- R7: `rx_bit_out` keeps its value on every clock where `rx_valid` is 0.
- R8: Bit inputs presented on clocks without a slot strobe have no effect on run counting or on the outputs.
- R9: A 0 within a run resets the ones count. Four ones, a 0, then four ones cause no stuffing or deletion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_stuff_en | input | 1 | Enables zero insertion on transmit |
| rx_destuff_en | input | 1 | Enables zero removal on receive |
| tx_slot | input | 1 | Strobe for an outgoing link-bit slot |
| tx_bit_in | input | 1 | Link bit offered for the slot |
| tx_ready | output | 1 | Offered bit is taken in this slot |
| tx_valid | output | 1 | Pulse: `tx_bit_out` updated |
| tx_bit_out | output | 1 | Bit placed in the framing slot |
| rx_slot | input | 1 | Strobe for an incoming link bit |
| rx_bit_in | input | 1 | Extracted link bit |
| rx_valid | output | 1 | Pulse: `rx_bit_out` updated |
| rx_bit_out | output | 1 | Destuffed link bit, held between updates |

## Verification
`tx_ready` is combinational. It is checked 1 ns after the inputs are driven, in the same cycle as the strobe. Both valid outputs and both bit outputs are due one clock after the strobe that produces them. A behavioural model therefore predicts them when the inputs are driven, and the bench compares them at the following falling edge. Between strobes, the model expects no valid pulses, and it expects the bit outputs to stay unchanged while random values toggle the bit inputs.

// File: rtl/fdl_codec_pkg.sv
package fdl_codec_pkg;
   // Width of a ones-run counter able to hold run_len+1
   function automatic int run_cnt_w(input int run_len);
      return $clog2(run_len + 2);
   endfunction
endpackage

// File: rtl/fdl_run_ctr.sv
module fdl_run_ctr #(
   parameter int RUN_LEN  = 5,
   parameter bit SATURATE = 1'b0,
   localparam int CNT_W   = fdl_codec_pkg::run_cnt_w(RUN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             one,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(RUN_LEN + 1);
   logic [CNT_W-1:0] inc;

   generate
      if (SATURATE) begin : g_sat
         assign inc = (count == CAP) ? CAP : count + 1'b1;
      end else begin : g_wrap
         assign inc = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               count <= '0;
      else if (step) begin
         if (clear || !one)     count <= '0;
         else                   count <= inc;
      end
   end
endmodule

// File: rtl/fdl_stuffer.sv
module fdl_stuffer #(
   parameter int RUN_LEN = 5,
   localparam int CNT_W  = fdl_codec_pkg::run_cnt_w(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slot,
   input  logic bit_in,
   output logic ready,
   output logic vld,
   output logic bit_out
);
   localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN_LEN);
   logic [CNT_W-1:0] cnt;
   logic             insert;

   assign insert = en && (cnt == RUN_C);
   assign ready  = !insert;

   fdl_run_ctr #(.RUN_LEN(RUN_LEN), .SATURATE(1'b0)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(slot),
      .one(bit_in), .clear(!en || insert), .count(cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         vld <= slot;
         if (slot) bit_out <= insert ? 1'b0 : bit_in;
      end
   end

   AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && en && cnt == RUN_C) |=> (vld && !bit_out)); // R2
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt <= RUN_C)); // R2
endmodule

// File: rtl/fdl_destuffer.sv
module fdl_destuffer #(
   parameter int RUN_LEN = 5,
   localparam int CNT_W  = fdl_codec_pkg::run_cnt_w(RUN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slot,
   input  logic bit_in,
   output logic vld,
   output logic bit_out
);
   localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN_LEN);
   logic [CNT_W-1:0] cnt;
   logic             drop;

   assign drop = en && !bit_in && (cnt == RUN_C);

   fdl_run_ctr #(.RUN_LEN(RUN_LEN), .SATURATE(1'b1)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(slot),
      .one(bit_in), .clear(!en), .count(cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         vld <= slot && !drop;
         if (slot && !drop) bit_out <= bit_in;
      end
   end

   AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && en && !bit_in && cnt == RUN_C) |=> !vld); // R3
   AST_KEEP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && en && cnt > RUN_C) |=> vld); // R4
endmodule

// File: rtl/fdl_link_codec.sv
module fdl_link_codec #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_stuff_en,
   input  logic rx_destuff_en,
   input  logic tx_slot,
   input  logic tx_bit_in,
   output logic tx_ready,
   output logic tx_valid,
   output logic tx_bit_out,
   input  logic rx_slot,
   input  logic rx_bit_in,
   output logic rx_valid,
   output logic rx_bit_out
);
   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("RUN_LEN must be at least 2");
      end
   endgenerate

   fdl_stuffer #(.RUN_LEN(RUN_LEN)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_stuff_en), .slot(tx_slot),
      .bit_in(tx_bit_in), .ready(tx_ready), .vld(tx_valid), .bit_out(tx_bit_out)
   );

   fdl_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_destuff_en), .slot(rx_slot),
      .bit_in(rx_bit_in), .vld(rx_valid), .bit_out(rx_bit_out)
   );

   AST_TX_VLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_slot)); // R6
   AST_RX_VLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(rx_slot)); // R6
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_bit_out)); // R7
endmodule

// File: tb/fdl_link_codec_tb.sv
module fdl_link_codec_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RUN = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_stuff_en = 1'b1, rx_destuff_en = 1'b1;
   logic tx_slot = 1'b0, tx_bit_in = 1'b0, rx_slot = 1'b0, rx_bit_in = 1'b0;
   logic tx_ready, tx_valid, tx_bit_out, rx_valid, rx_bit_out;

   int checks = 0, errors = 0;
   int m_tones = 0, m_rones = 0;
   logic e_txv = 0, e_txb = 0, e_rxv = 0, e_rxb = 0;
   string tx_tag = "R6", rx_tag = "R6";
   bit tq[$];
   bit rq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   fdl_link_codec #(.RUN_LEN(RUN)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_stuff_en(tx_stuff_en),
      .rx_destuff_en(rx_destuff_en), .tx_slot(tx_slot), .tx_bit_in(tx_bit_in),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_bit_out(tx_bit_out),
      .rx_slot(rx_slot), .rx_bit_in(rx_bit_in), .rx_valid(rx_valid),
      .rx_bit_out(rx_bit_out)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // one clock: compare last prediction, drive inputs, predict next outputs
   task automatic cycle(input bit ts, input bit tb, input bit rs, input bit rb);
      bit ins, drop;
      @(negedge clk);
      chk(tx_tag, "tx_valid", tx_valid, e_txv);
      chk(tx_tag, "tx_bit_out", tx_bit_out, e_txb);
      chk(rx_tag, "rx_valid", rx_valid, e_rxv);
      chk("R7", "rx_bit_out", rx_bit_out, e_rxb);
      tx_slot = ts; tx_bit_in = tb; rx_slot = rs; rx_bit_in = rb;
      #1;
      ins = tx_stuff_en && (m_tones == RUN);
      chk(tx_stuff_en ? "R2" : "R5", "tx_ready", tx_ready, !ins);
      e_txv = ts;
      tx_tag = ts ? (ins ? "R2" : (tx_stuff_en ? "R9" : "R5")) : "R8";
      if (ts) begin
         e_txb = ins ? 1'b0 : tb;
         if (!tx_stuff_en || ins || !tb) m_tones = 0;
         else m_tones++;
      end
      drop = rx_destuff_en && !rb && (m_rones == RUN);
      rx_tag = !rs ? "R8" : drop ? "R3" : (m_rones > RUN && !rb && rx_destuff_en) ? "R4"
               : (rx_destuff_en ? "R6" : "R5");
      e_rxv = rs && !drop;
      if (rs) begin
         if (!drop) e_rxb = rb;
         if (!rx_destuff_en || !rb) m_rones = 0;
         else if (m_rones <= RUN) m_rones++;
      end
   endtask

   // play queued bits, one slot every GAP clocks, noise on bit inputs in between
   task automatic drain(input int gap);
      while (tq.size() > 0 || rq.size() > 0) begin
         bit ts, tb, rs, rb, ins;
         for (int g = 0; g < gap; g++) cycle(0, 1'($urandom), 0, 1'($urandom));
         ins = tx_stuff_en && (m_tones == RUN);
         ts = tq.size() > 0; tb = ts ? tq[0] : 1'b0;
         rs = rq.size() > 0; rb = rs ? rq[0] : 1'b0;
         if (ts && !ins) void'(tq.pop_front());
         if (rs) void'(rq.pop_front());
         cycle(ts, tb, rs, rb);
      end
      cycle(0, 0, 0, 0);
   endtask

   task automatic push_run(input int n, input bit v, input bit to_tx);
      for (int i = 0; i < n; i++) if (to_tx) tq.push_back(v); else rq.push_back(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "tx_valid", tx_valid, 0);
      chk("R1", "rx_valid", rx_valid, 0);
      chk("R1", "tx_bit_out", tx_bit_out, 0);
      chk("R1", "rx_bit_out", rx_bit_out, 0);
      chk("R1", "tx_ready", tx_ready, 1);
      rst_n = 1'b1;
      // directed: long runs, exact runs, broken runs
      push_run(7, 1, 1); push_run(1, 0, 1); push_run(4, 1, 1); push_run(1, 0, 1);
      push_run(4, 1, 1); push_run(5, 1, 1); push_run(1, 0, 1); push_run(11, 1, 1);
      push_run(5, 1, 0); push_run(1, 0, 0); push_run(6, 1, 0); push_run(1, 0, 0);
      push_run(7, 1, 0); push_run(1, 0, 0); push_run(4, 1, 0); push_run(1, 0, 0);
      push_run(4, 1, 0); push_run(5, 1, 0); push_run(1, 1, 0); push_run(1, 0, 0);
      drain(3);
      // random dense ones
      for (int i = 0; i < 400; i++) begin
         tq.push_back(($urandom % 10) < 8);
         rq.push_back(($urandom % 10) < 8);
      end
      drain(2);
      // pass-through
      tx_stuff_en = 1'b0; rx_destuff_en = 1'b0;
      push_run(12, 1, 1); push_run(1, 0, 1); push_run(5, 1, 0); push_run(1, 0, 0);
      push_run(8, 1, 0); push_run(1, 0, 0);
      drain(1);
      // re-enable, back-to-back slots
      tx_stuff_en = 1'b1; rx_destuff_en = 1'b1;
      for (int i = 0; i < 200; i++) begin
         tq.push_back(($urandom % 4) != 0);
         rq.push_back(($urandom % 4) != 0);
      end
      drain(0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule